// File: doc/BRIEF.md
# Streaming Max-Pooling Engine

This block reduces a raster-ordered feature map to its max-pooled form while the map streams past. It takes one signed sample per cycle on a valid/data input and has no ready signal, so it never stalls its source. Rows that later windows will need are stored in on-chip row stores. Each sample is therefore read from the stream exactly once, and no window is fetched again from memory.

For every accepted sample, a column of KERN vertically aligned samples is shifted into a KERN by KERN register window. The newest row comes from the input and the older rows come from the row stores. A window is complete when the current sample is its bottom-right corner, that is, when the column and row positions both fall on the stride grid. The window then goes through a registered tree of pairwise signed comparators. Each tree level halves the element count and passes any unpaired element through unchanged, until a single maximum reaches the output.

Image width, image height, kernel size, stride and sample width are parameters. The position counters wrap at the end of each frame, so frames can follow each other with no idle cycles between them.

Top module: `maxpool_stream`

## Requirements
- R1: Each output value is the maximum of the KERN by KERN samples whose top-left sample sits at a row and column that are both multiples of STRIDE (STRIDE defaults to KERN, giving non-overlapping windows).
- R2: Samples are compared as two's complement signed values of DATA_W bits, so -1 is larger than -128 and 127 is the largest code.
- R3: For each frame, exactly (IMG_W/KERN)*(IMG_H/KERN) outputs are produced, in raster order of the windows. out_valid is never high for two cycles in a row, and no output appears that does not belong to a window.
- R4: out_valid is high in the cycle after clock edge E+LAT, where E is the edge that accepts the window's bottom-right sample and LAT = ceil(log2(KERN*KERN)). With the defaults, LAT is 4.
- R5: A cycle with in_valid low changes no state. Results and their timing relative to the accepted samples are the same as for a gap-free stream.
- R6: A sample is accepted on every edge where in_valid is high. A stream with in_valid held high for a whole frame gives correct results.
- R7: After IMG_W*IMG_H accepted samples the position counters return to row 0, column 0. Windows of the next frame use only that frame's samples, even when it follows the previous frame with no gap.
- R8: While rst_n is low, and after its release until the first window completes, out_valid is low.
- R9: The result is correct wherever the maximum lies in the window, including the last element (row-major index KERN*KERN-1). When KERN*KERN is odd, that element passes unpaired through the first tree level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | DATA_W | Signed input sample, raster order |
| out_valid | output | 1 | Pooled result present this cycle |
| out_data | output | DATA_W | Signed window maximum |

## Verification
The hardest case to reach from the ports is a window whose maximum is the lone element that the comparator tree carries without a partner. Random images seldom put the maximum there, and when they do it is hidden among other windows. The bench plants one clear maximum per window on a flat background and rotates its position through all nine slots over two frames, so every path through the tree is used alone. A second hard case is a frame that starts straight after another whose row stores still hold larger values. The bench sends a frame of large positive values followed at once by a frame of negative values, and checks that no stale sample leaks into the second frame.

// File: rtl/pool_pkg.sv
`timescale 1ns/1ps
package pool_pkg;

  // Number of elements that remain before tree level lvl
  function automatic int unsigned level_count(int unsigned n, int unsigned lvl);
    return (n + (32'd1 << lvl) - 1) >> lvl;
  endfunction

  // True when position pos is the last row/column of a window on the stride grid
  function automatic logic closes_window(int unsigned pos, int unsigned k, int unsigned s);
    if (pos < k - 1) return 1'b0;
    return ((pos - (k - 1)) % s) == 0;
  endfunction

endpackage

// File: rtl/pool_linebuf.sv
`timescale 1ns/1ps
module pool_linebuf #(
  parameter int DATA_W = 8,
  parameter int IMG_W  = 9,
  parameter int KERN   = 3,
  localparam int CW    = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
  input  logic              clk,
  input  logic              acc,
  input  logic [CW-1:0]     col,
  input  logic [DATA_W-1:0] din,
  // col_o[0] is the newest row, col_o[KERN-1] the oldest
  output logic [DATA_W-1:0] col_o [KERN]
);

  assign col_o[0] = din;

  generate
    if (KERN > 1) begin : g_rows
      logic [DATA_W-1:0] store [KERN-1][IMG_W];

      always_ff @(posedge clk) begin
        if (acc) begin
          store[0][col] <= din;
          for (int r = 1; r < KERN - 1; r++) begin
            store[r][col] <= store[r-1][col];
          end
        end
      end

      for (genvar r = 0; r < KERN - 1; r++) begin : g_tap
        assign col_o[r+1] = store[r][col];
      end
    end
  endgenerate

endmodule

// File: rtl/pool_window.sv
`timescale 1ns/1ps
module pool_window
  import pool_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IMG_W  = 9,
  parameter int IMG_H  = 6,
  parameter int KERN   = 3,
  parameter int STRIDE = KERN,
  localparam int CW    = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int RW    = (IMG_H > 1) ? $clog2(IMG_H) : 1,
  localparam int N     = KERN * KERN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] col_i [KERN],
  output logic [CW-1:0]     col_o,
  output logic [DATA_W-1:0] win_o [N],
  output logic              win_vld_o
);

  logic [CW-1:0]     col_q;
  logic [RW-1:0]     row_q;
  logic              win_vld_q;
  logic              close_evt;
  logic              last_col;
  logic              last_row;
  logic [DATA_W-1:0] win_q [KERN][KERN];

  assign last_col  = (col_q == CW'(IMG_W - 1));
  assign last_row  = (row_q == RW'(IMG_H - 1));
  assign close_evt = in_valid
                   && closes_window(int'(col_q), KERN, STRIDE)
                   && closes_window(int'(row_q), KERN, STRIDE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q     <= '0;
      row_q     <= '0;
      win_vld_q <= 1'b0;
    end else begin
      win_vld_q <= close_evt;
      if (in_valid) begin
        if (last_col) begin
          col_q <= '0;
          row_q <= last_row ? '0 : row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  // Window rows: 0 is the top (oldest), KERN-1 the bottom (newest)
  generate
    for (genvar r = 0; r < KERN; r++) begin : g_wr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int c = 0; c < KERN; c++) win_q[r][c] <= '0;
        end else if (in_valid) begin
          for (int c = 0; c < KERN - 1; c++) win_q[r][c] <= win_q[r][c+1];
          win_q[r][KERN-1] <= col_i[KERN-1-r];
        end
      end
      for (genvar c = 0; c < KERN; c++) begin : g_wc
        assign win_o[r*KERN + c] = win_q[r][c];
      end
    end
  endgenerate

  assign col_o     = col_q;
  assign win_vld_o = win_vld_q;

  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(col_q) && $stable(row_q) && !win_vld_q)); // R5

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && last_col && last_row) |=> (col_q == '0 && row_q == '0)); // R7

  generate
    if (STRIDE > 1 && KERN > 1) begin : g_spacing
      AST_CLOSE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld_q |=> !win_vld_q); // R3
    end
  endgenerate

endmodule

// File: rtl/pool_maxtree.sv
`timescale 1ns/1ps
module pool_maxtree
  import pool_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int N      = 9,
  localparam int LAT   = (N > 1) ? $clog2(N) : 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] elem_i [N],
  output logic              vld_o,
  output logic [DATA_W-1:0] max_o
);

  function automatic logic [DATA_W-1:0] pick_max(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    return ($signed(a) >= $signed(b)) ? a : b;
  endfunction

  logic [DATA_W-1:0] lvl_q [LAT+1][N];
  logic              vld_q [LAT+1];

  assign vld_q[0] = vld_i;
  generate
    for (genvar i = 0; i < N; i++) begin : g_in
      assign lvl_q[0][i] = elem_i[i];
    end

    for (genvar l = 0; l < LAT; l++) begin : g_lvl
      localparam int CNT = int'(level_count(N, l));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q[l+1] <= 1'b0;
        else        vld_q[l+1] <= vld_q[l];
      end

      for (genvar i = 0; i < N; i++) begin : g_node
        if (2*i + 1 < CNT) begin : g_pair
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q[l+1][i] <= '0;
            else        lvl_q[l+1][i] <= pick_max(lvl_q[l][2*i], lvl_q[l][2*i+1]);
          end

          AST_PAIR_MAX: assert property (@(posedge clk) disable iff (!rst_n)
            vld_q[l+1] |-> ($signed(lvl_q[l+1][i]) >= $signed($past(lvl_q[l][2*i]))
                         && $signed(lvl_q[l+1][i]) >= $signed($past(lvl_q[l][2*i+1])))); // R2
        end else if (2*i < CNT) begin : g_pass
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q[l+1][i] <= '0;
            else        lvl_q[l+1][i] <= lvl_q[l][2*i];
          end
        end else begin : g_idle
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q[l+1][i] <= '0;
            else        lvl_q[l+1][i] <= '0;
          end
        end
      end
    end
  endgenerate

  assign vld_o = vld_q[LAT];
  assign max_o = lvl_q[LAT][0];

endmodule

// File: rtl/maxpool_stream.sv
`timescale 1ns/1ps
module maxpool_stream #(
  parameter int DATA_W = 8,
  parameter int IMG_W  = 9,
  parameter int IMG_H  = 6,
  parameter int KERN   = 3,
  parameter int STRIDE = KERN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int CW = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int N  = KERN * KERN;

  logic [CW-1:0]     pix_col;
  logic [DATA_W-1:0] col_vec   [KERN];
  logic [DATA_W-1:0] win_elems [N];
  logic              win_vld;

  pool_linebuf #(.DATA_W(DATA_W), .IMG_W(IMG_W), .KERN(KERN)) lbuf_i (
    .clk   (clk),
    .acc   (in_valid),
    .col   (pix_col),
    .din   (in_data),
    .col_o (col_vec)
  );

  pool_window #(.DATA_W(DATA_W), .IMG_W(IMG_W), .IMG_H(IMG_H),
                .KERN(KERN), .STRIDE(STRIDE)) win_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .col_i     (col_vec),
    .col_o     (pix_col),
    .win_o     (win_elems),
    .win_vld_o (win_vld)
  );

  pool_maxtree #(.DATA_W(DATA_W), .N(N)) tree_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (win_vld),
    .elem_i (win_elems),
    .vld_o  (out_valid),
    .max_o  (out_data)
  );

  AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_data)); // R1

  generate
    if (STRIDE > 1 && KERN > 1) begin : g_out_gap
      AST_OUT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R3
    end
  endgenerate

endmodule

// File: tb/maxpool_stream_tb_top.sv
`timescale 1ns/1ps
module maxpool_stream_tb_top;

  localparam int W    = 9;
  localparam int H    = 6;
  localparam int K    = 3;
  localparam int LAT  = 4;               // ceil(log2(9))
  localparam int PF   = W * H;
  localparam int NWF  = (W / K) * (H / K);
  localparam int MAXF = 2;
  localparam int MAXG = 32;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_data;
  logic       out_valid;
  logic [7:0] out_data;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int ngot = 0;
  bit done = 0;

  logic signed [7:0] pix [MAXF*PF];
  int acc_cyc [MAXF*PF];
  int got_val [MAXG];
  int got_cyc [MAXG];

  maxpool_stream #(.DATA_W(8), .IMG_W(W), .IMG_H(H), .KERN(K)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid && ngot < MAXG) begin
      got_val[ngot] = int'($signed(out_data));
      got_cyc[ngot] = cyc;
      ngot++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive nf frames from pix, then compare every pooled result
  task automatic run_stream(input int nf, input int gap, input string vreq, input bit lat);
    int m, cp, ei, v;
    ngot = 0;
    for (int p = 0; p < nf * PF; p++) begin
      while (gap > 0 && $urandom_range(99) < gap) begin
        in_valid = 1'b0;
        in_data  = 8'($urandom_range(255));
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = pix[p];
      @(negedge clk);
      acc_cyc[p] = cyc;
    end
    in_valid = 1'b0;
    repeat (LAT + 4) @(negedge clk);
    check(ngot == nf * NWF, "R3 count", ngot, nf * NWF);
    for (int f = 0; f < nf; f++) begin
      for (int wr = 0; wr < H / K; wr++) begin
        for (int wc = 0; wc < W / K; wc++) begin
          m = -1000;
          for (int i = 0; i < K; i++)
            for (int j = 0; j < K; j++) begin
              v = int'(pix[f*PF + (wr*K + i)*W + wc*K + j]);
              if (v > m) m = v;
            end
          cp = f*PF + (wr*K + K - 1)*W + wc*K + K - 1;
          ei = f*NWF + wr*(W/K) + wc;
          if (ei < ngot) begin
            check(got_val[ei] == m, vreq, got_val[ei], m);
            if (lat) check(got_cyc[ei] == acc_cyc[cp] + LAT, "R4 latency",
                           got_cyc[ei] - acc_cyc[cp], LAT);
          end
        end
      end
    end
  endtask

  task automatic fill_range(input int nf, input int lo, input int hi);
    for (int p = 0; p < nf * PF; p++) pix[p] = 8'(lo + int'($urandom_range(hi - lo)));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R8 after reset", int'(out_valid), 0);
    end
  endtask

  task automatic t_random();      // R1 R6 R4: gap-free random stream
    fill_range(1, -128, 127);
    run_stream(1, 0, "R1 random", 1'b1);
  endtask

  task automatic t_gaps();        // R5: idle cycles in the stream
    fill_range(1, -128, 127);
    run_stream(1, 40, "R5 gaps", 1'b1);
  endtask

  task automatic t_signed();      // R2: negative values and both extremes
    fill_range(1, -128, -1);
    pix[0]  = 8'sd127;
    pix[13] = -8'sd128;
    pix[40] = 8'sd0;
    run_stream(1, 0, "R2 signed", 1'b0);
  endtask

  task automatic t_position();    // R9: max at each of the nine window slots
    int w, pos;
    for (int p = 0; p < 2 * PF; p++) pix[p] = -8'sd100;
    for (int f = 0; f < 2; f++)
      for (int wr = 0; wr < H / K; wr++)
        for (int wc = 0; wc < W / K; wc++) begin
          w   = wr * (W / K) + wc;
          pos = (w + f * NWF) % (K * K);
          pix[f*PF + (wr*K + pos / K)*W + wc*K + pos % K] = 8'(10 + w + f * 8);
        end
    run_stream(2, 0, "R9 position", 1'b1);
  endtask

  task automatic t_frames();      // R7: large frame then small frame, no gap
    for (int p = 0; p < PF; p++) pix[p] = 8'(100 + int'($urandom_range(27)));
    for (int p = PF; p < 2 * PF; p++) pix[p] = 8'(-128 + int'($urandom_range(27)));
    run_stream(2, 0, "R7 frame wrap", 1'b1);
  endtask

  initial begin
    t_reset();
    t_random();
    t_gaps();
    t_signed();
    t_position();
    t_frames();
    t_random();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule